// File: doc/BRIEF.md
# Converter write sequencer

This block sits on the host side of a double-buffered converter input. It takes one 16-bit word at a time on a valid/ready handshake and plays it onto the converter's data bus, two byte-enable strobes and a load strobe. The load strobe moves the staged bytes into the converter's holding register. Every phase lasts a whole number of system clock cycles. That number is computed from a clock-period parameter and the nanosecond minimum for the phase: `ceil(ns / period)`, and never less than one cycle.

Each word carries its own bus-mode flag. In narrow mode the word is written as two bytes on the low lane, low byte first, and a load pulse follows. In wide mode the whole word is placed on the bus, both enables pulse together once, and a load pulse follows. Each strobe pulse is preceded by a setup phase with the bus already steady, and each enable is followed by a hold phase with the bus unchanged. The block drops its ready while a word is in flight and raises it again in the cycle the load strobe falls.

Top module: `conv_wr_seq`

## Requirements
- R1: After reset `in_ready` is 1, the three strobes are 0 and `cv_data` is all zeros.
- R2: A word is taken at a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 while any strobe is high and returns to 1 in the cycle the load strobe falls. A word offered meanwhile waits.
- R3: In narrow mode the low-byte enable pulses once, then the high-byte enable pulses once, then the load strobe pulses once. The load strobe is never high together with either enable.
- R4: Each enable pulse lasts exactly EN = ceil(800 ns / period) cycles, and at least 1 cycle.
- R5: `cv_data` has been unchanged for at least SU = ceil(200 ns / period) cycles when any enable or the load strobe rises.
- R6: `cv_data` does not change while a strobe is high. After an enable falls, it stays unchanged for at least HD = ceil(200 ns / period) cycles.
- R7: The load pulse lasts exactly LD = ceil(600 ns / period) cycles.
- R8: In narrow mode the byte being written is on `cv_data[7:0]`, with bits 7:0 of the word during the low-byte enable and bits 15:8 during the high-byte enable. `cv_data[15:8]` is 0 throughout.
- R9: In wide mode (`in_wide` = 1 at acceptance) both enables rise and fall together, exactly once. The full word is on `cv_data[15:0]`, and one load pulse follows.
- R10: The word and mode flag are captured at acceptance. Changes on `in_data` and `in_wide` after that edge have no effect on the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | Sequencer idle and able to take a word |
| in_data | input | 16 | Word to write |
| in_wide | input | 1 | 1: one combined 16-bit write; 0: two byte writes |
| cv_data | output | 16 | Converter data bus |
| cv_lo_en | output | 1 | Low-byte enable strobe (level) |
| cv_hi_en | output | 1 | High-byte enable strobe (level) |
| cv_xfer | output | 1 | Load strobe to the holding register (level) |

## Verification
The embedded properties assume only that `in_valid`, `in_data` and `in_wide` are synchronous to `clk` and free of X after reset. They assume nothing about how long the host holds a word or when it changes its inputs. The stimulus keeps to these assumptions: it drives every input on the falling edge. It also leans on the lack of other assumptions by holding `in_valid` high across busy periods and by scrambling `in_data` and `in_wide` right after each acceptance. A converter model in the bench latches the bus on the level-actuated strobes. Its holding register must equal each accepted word, in both modes, with identical bytes, all-zero and all-one words.

// File: rtl/conv_wr_pkg.sv
package conv_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP_LO,
    ST_EN_LO,
    ST_HOLD_LO,
    ST_SETUP_HI,
    ST_EN_HI,
    ST_HOLD_HI,
    ST_LOAD
  } seq_state_e;

  // Whole clock cycles covering a nanosecond minimum, never below one.
  function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/conv_wr_timer.sv
module conv_wr_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/conv_wr_fsm.sv
module conv_wr_fsm
  import conv_wr_pkg::*;
#(
  parameter int unsigned CW        = 8,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned EN_CYC    = 1,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned LOAD_CYC  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_wide,
  output logic       accept,
  output seq_state_e state_nxt,
  output logic       wide_eff,
  output logic       wide_q
);

  seq_state_e    state_q;
  logic          expired;
  logic          t_load;
  logic [CW-1:0] t_val;

  // Reload value: dwell length of the state being entered, minus one.
  function automatic logic [CW-1:0] dwell(seq_state_e s);
    case (s)
      ST_SETUP_LO, ST_SETUP_HI: return CW'(SETUP_CYC - 1);
      ST_EN_LO, ST_EN_HI:       return CW'(EN_CYC - 1);
      ST_HOLD_LO, ST_HOLD_HI:   return CW'(HOLD_CYC - 1);
      ST_LOAD:                  return CW'(LOAD_CYC - 1);
      default:                  return '0;
    endcase
  endfunction

  assign accept   = in_valid && (state_q == ST_IDLE);
  assign wide_eff = accept ? in_wide : wide_q;

  always_comb begin
    state_nxt = state_q;
    case (state_q)
      ST_IDLE:     if (accept)  state_nxt = ST_SETUP_LO;
      ST_SETUP_LO: if (expired) state_nxt = ST_EN_LO;
      ST_EN_LO:    if (expired) state_nxt = ST_HOLD_LO;
      ST_HOLD_LO:  if (expired) state_nxt = wide_q ? ST_LOAD : ST_SETUP_HI;
      ST_SETUP_HI: if (expired) state_nxt = ST_EN_HI;
      ST_EN_HI:    if (expired) state_nxt = ST_HOLD_HI;
      ST_HOLD_HI:  if (expired) state_nxt = ST_LOAD;
      ST_LOAD:     if (expired) state_nxt = ST_IDLE;
      default:                  state_nxt = ST_IDLE;
    endcase
  end

  assign t_load = (state_nxt != state_q);
  assign t_val  = dwell(state_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wide_q  <= 1'b0;
    end else begin
      state_q <= state_nxt;
      if (accept) wide_q <= in_wide;
    end
  end

  conv_wr_timer #(.CW(CW)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (expired)
  );

  // A timed phase is left only once its counter has run out (R4, R7).
  assert_dwell_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !expired) |=> (state_q == $past(state_q)));

endmodule

// File: rtl/conv_wr_drive.sv
module conv_wr_drive
  import conv_wr_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_nxt,
  input  logic              accept,
  input  logic              wide_eff,
  input  logic              wide_q,
  input  logic [WORD_W-1:0] in_data,
  output logic [WORD_W-1:0] cv_data,
  output logic              cv_lo_en,
  output logic              cv_hi_en,
  output logic              cv_xfer,
  output logic              in_ready
);

  logic [WORD_W-1:0] word_q, word_src, data_d;
  logic [BYTE_W-1:0] byte_lo, byte_hi;
  logic              lo_en_d, hi_en_d, xfer_d, ready_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (accept) word_q <= in_data;
  end

  assign word_src = accept ? in_data : word_q;
  assign byte_lo  = word_src[BYTE_W-1:0];
  assign byte_hi  = word_src[WORD_W-1:BYTE_W];

  // Strobe and bus values follow the next state so they line up with it.
  always_comb begin
    lo_en_d = (state_nxt == ST_EN_LO);
    hi_en_d = (state_nxt == ST_EN_HI) || ((state_nxt == ST_EN_LO) && wide_eff);
    xfer_d  = (state_nxt == ST_LOAD);
    ready_d = (state_nxt == ST_IDLE);
    case (state_nxt)
      ST_SETUP_LO, ST_EN_LO, ST_HOLD_LO:
        data_d = wide_eff ? word_src : {{BYTE_W{1'b0}}, byte_lo};
      ST_SETUP_HI, ST_EN_HI, ST_HOLD_HI:
        data_d = {{BYTE_W{1'b0}}, byte_hi};
      default:
        data_d = cv_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv_data  <= '0;
      cv_lo_en <= 1'b0;
      cv_hi_en <= 1'b0;
      cv_xfer  <= 1'b0;
      in_ready <= 1'b1;
    end else begin
      cv_data  <= data_d;
      cv_lo_en <= lo_en_d;
      cv_hi_en <= hi_en_d;
      cv_xfer  <= xfer_d;
      in_ready <= ready_d;
    end
  end

  assert_joint_enables_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_q && !in_ready) |-> (cv_lo_en == cv_hi_en));

  assert_upper_lane_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_q && (cv_lo_en || cv_hi_en)) |-> (cv_data[WORD_W-1:BYTE_W] == '0));

endmodule

// File: rtl/conv_wr_seq.sv
module conv_wr_seq
  import conv_wr_pkg::*;
#(
  parameter int unsigned BYTE_W       = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned SETUP_NS     = 200,
  parameter int unsigned EN_NS        = 800,
  parameter int unsigned HOLD_NS      = 200,
  parameter int unsigned LOAD_NS      = 600
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [2*BYTE_W-1:0] in_data,
  input  logic                in_wide,
  output logic [2*BYTE_W-1:0] cv_data,
  output logic                cv_lo_en,
  output logic                cv_hi_en,
  output logic                cv_xfer
);

  localparam int unsigned WORD_W    = 2 * BYTE_W;
  localparam int unsigned SETUP_CYC = ns_to_cycles(SETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned EN_CYC    = ns_to_cycles(EN_NS, CLK_PERIOD_NS);
  localparam int unsigned HOLD_CYC  = ns_to_cycles(HOLD_NS, CLK_PERIOD_NS);
  localparam int unsigned LOAD_CYC  = ns_to_cycles(LOAD_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC   = max4(SETUP_CYC, EN_CYC, HOLD_CYC, LOAD_CYC);
  localparam int unsigned CW        = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam int unsigned AW        = $clog2(MAX_CYC + 1) + 1;

  seq_state_e state_nxt;
  logic       accept, wide_eff, wide_q;

  conv_wr_fsm #(
    .CW(CW), .SETUP_CYC(SETUP_CYC), .EN_CYC(EN_CYC),
    .HOLD_CYC(HOLD_CYC), .LOAD_CYC(LOAD_CYC)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_wide   (in_wide),
    .accept    (accept),
    .state_nxt (state_nxt),
    .wide_eff  (wide_eff),
    .wide_q    (wide_q)
  );

  conv_wr_drive #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) drive_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_nxt (state_nxt),
    .accept    (accept),
    .wide_eff  (wide_eff),
    .wide_q    (wide_q),
    .in_data   (in_data),
    .cv_data   (cv_data),
    .cv_lo_en  (cv_lo_en),
    .cv_hi_en  (cv_hi_en),
    .cv_xfer   (cv_xfer),
    .in_ready  (in_ready)
  );

  // Observation counters for the timing properties below.
  logic [AW-1:0]     lo_len, hi_len, ld_len, bus_age;
  logic [WORD_W-1:0] bus_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_len   <= '0;
      hi_len   <= '0;
      ld_len   <= '0;
      bus_age  <= '1;
      bus_prev <= '0;
    end else begin
      lo_len   <= cv_lo_en ? lo_len + 1'b1 : '0;
      hi_len   <= cv_hi_en ? hi_len + 1'b1 : '0;
      ld_len   <= cv_xfer  ? ld_len + 1'b1 : '0;
      bus_prev <= cv_data;
      if (cv_data != bus_prev)  bus_age <= '0;
      else if (bus_age != '1)   bus_age <= bus_age + 1'b1;
    end
  end

  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_lo_en || cv_hi_en || cv_xfer) |-> !in_ready);

  assert_ready_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cv_xfer) |-> in_ready);

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cv_xfer && (cv_lo_en || cv_hi_en)));

  assert_lo_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cv_lo_en) |-> (lo_len == AW'(EN_CYC)));

  assert_hi_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cv_hi_en) |-> (hi_len == AW'(EN_CYC)));

  // bus_age lags the bus by one register, hence the +1.
  assert_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cv_lo_en) || $rose(cv_hi_en) || $rose(cv_xfer))
      |-> ((AW + 1)'(bus_age) + 1'b1 >= (AW + 1)'(SETUP_CYC)));

  assert_bus_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_lo_en || cv_hi_en || cv_xfer) |=> $stable(cv_data));

  assert_load_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cv_xfer) |-> (ld_len == AW'(LOAD_CYC)));

endmodule

// File: tb/conv_wr_seq_tb.sv
module conv_wr_seq_tb_top;

  localparam int T   = 10;
  localparam int SU  = ((200 + T - 1) / T) < 1 ? 1 : (200 + T - 1) / T;
  localparam int EN  = ((800 + T - 1) / T) < 1 ? 1 : (800 + T - 1) / T;
  localparam int HD  = ((200 + T - 1) / T) < 1 ? 1 : (200 + T - 1) / T;
  localparam int LD  = ((600 + T - 1) / T) < 1 ? 1 : (600 + T - 1) / T;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        in_wide = 1'b0;
  logic [15:0] cv_data;
  logic        cv_lo_en, cv_hi_en, cv_xfer;

  always #(T/2) clk = ~clk;

  conv_wr_seq #(.CLK_PERIOD_NS(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_wide(in_wide), .cv_data(cv_data),
    .cv_lo_en(cv_lo_en), .cv_hi_en(cv_hi_en), .cv_xfer(cv_xfer)
  );

  int n_chk = 0;
  int n_fail = 0;
  int n_xfer = 0;
  bit done = 0;
  bit mon_on = 0;
  logic [16:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: offers a word, records it once it is certain to be taken,
  // then scrambles the inputs (R10).
  task automatic send(input bit wide, input logic [15:0] word);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = word;
    in_wide  = wide;
    while (!in_ready) @(negedge clk);
    exp_q.push_back({wide, word});
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = ~word;
    in_wide  = ~wide;
  endtask

  // Monitor with a converter model and timing counters.
  logic        p_lo, p_hi, p_ld;
  logic [15:0] p_bus;
  int bus_age, hold_age, lo_len, hi_len, ld_len;
  bit hold_pend;
  int n_lo, n_hi, n_joint;
  logic [7:0]  m_lo, m_hi;
  logic [15:0] m_hold;

  always @(negedge clk) begin
    if (!mon_on) begin
      p_lo = 0; p_hi = 0; p_ld = 0; p_bus = '0;
      bus_age = 1000; hold_age = 0; hold_pend = 0;
      lo_len = 0; hi_len = 0; ld_len = 0;
      n_lo = 0; n_hi = 0; n_joint = 0;
      m_lo = '0; m_hi = '0; m_hold = '0;
    end else begin
      if (hold_pend) hold_age++;
      if (cv_data != p_bus) begin
        if (hold_pend) chk(hold_age >= HD, "R6", "hold after enable fall", hold_age, HD);
        chk(!(p_lo || p_hi || p_ld), "R6", "bus moved during strobe", cv_data, p_bus);
        hold_pend = 0;
        bus_age = 0;
      end else bus_age++;

      if (cv_lo_en || cv_hi_en || cv_xfer)
        chk(!in_ready, "R2", "ready while busy", in_ready, 0);
      chk(!(cv_xfer && (cv_lo_en || cv_hi_en)), "R3", "load overlaps enable",
          {cv_xfer, cv_lo_en, cv_hi_en}, 3'b100);
      if (cv_lo_en != cv_hi_en)
        chk(cv_data[15:8] == 8'h00, "R8", "upper lane during byte write", cv_data[15:8], 0);

      // rising edges
      if (cv_lo_en && !p_lo) begin
        chk(bus_age >= SU, "R5", "setup before enable", bus_age, SU);
        if (cv_hi_en && !p_hi) n_joint++; else n_lo++;
      end else if (cv_hi_en && !p_hi) begin
        chk(bus_age >= SU, "R5", "setup before high enable", bus_age, SU);
        chk(n_lo == 1, "R3", "low byte before high byte", n_lo, 1);
        n_hi++;
      end
      if (cv_xfer && !p_ld) begin
        chk(bus_age >= SU, "R5", "setup before load", bus_age, SU);
        if (exp_q.size() == 0) chk(0, "R2", "load with no accepted word", 0, 1);
        else if (exp_q[0][16]) begin
          chk(n_joint == 1 && n_lo == 0 && n_hi == 0, "R9", "joint enable count",
              {n_joint[7:0], n_lo[7:0], n_hi[7:0]}, 24'h010000);
        end else begin
          chk(n_joint == 0 && n_lo == 1 && n_hi == 1, "R3", "byte enable count",
              {n_joint[7:0], n_lo[7:0], n_hi[7:0]}, 24'h000101);
        end
      end

      // converter model: level-actuated latches
      if (cv_lo_en && cv_hi_en) begin m_lo = cv_data[7:0]; m_hi = cv_data[15:8]; end
      else if (cv_lo_en) m_lo = cv_data[7:0];
      else if (cv_hi_en) m_hi = cv_data[7:0];
      if (cv_xfer) m_hold = {m_hi, m_lo};

      // widths and falling edges
      if (cv_lo_en) lo_len++;
      if (cv_hi_en) hi_len++;
      if (cv_xfer)  ld_len++;
      if (!cv_lo_en && p_lo) begin
        chk(lo_len == EN, "R4", "low enable width", lo_len, EN);
        lo_len = 0; hold_pend = 1; hold_age = 0;
      end
      if (!cv_hi_en && p_hi) begin
        chk(hi_len == EN, "R4", "high enable width", hi_len, EN);
        hi_len = 0; hold_pend = 1; hold_age = 0;
      end
      if (!cv_xfer && p_ld) begin
        chk(ld_len == LD, "R7", "load width", ld_len, LD);
        chk(in_ready, "R2", "ready as load falls", in_ready, 1);
        if (exp_q.size() != 0) begin
          logic [16:0] e;
          e = exp_q.pop_front();
          chk(m_hold == e[15:0], e[16] ? "R9" : "R8", "holding register (R10 scramble)",
              m_hold, e[15:0]);
        end
        n_xfer++;
        ld_len = 0; n_lo = 0; n_hi = 0; n_joint = 0;
      end

      p_lo = cv_lo_en; p_hi = cv_hi_en; p_ld = cv_xfer; p_bus = cv_data;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d transfers", n_xfer, 9);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
    chk({cv_lo_en, cv_hi_en, cv_xfer} == 3'b000, "R1", "strobes after reset",
        {cv_lo_en, cv_hi_en, cv_xfer}, 0);
    chk(cv_data == 16'h0000, "R1", "bus after reset", cv_data, 0);
    mon_on = 1;

    send(1'b0, 16'hA55A);
    send(1'b1, 16'h1234);   // offered while busy: waits (R2)
    send(1'b0, 16'h00FF);
    send(1'b1, 16'hFFFF);
    send(1'b0, 16'h0000);
    send(1'b1, 16'h0000);
    send(1'b0, 16'h3C3C);   // equal bytes: no bus change between byte phases
    send(1'b1, 16'h8001);
    send(1'b0, 16'hFF00);

    for (int i = 0; i < 2000 && (exp_q.size() != 0 || !in_ready); i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "words left unwritten", exp_q.size(), 0);
    chk(n_xfer == 9, "R3", "load pulses seen", n_xfer, 9);
    chk(in_ready && !cv_xfer, "R2", "idle at end", in_ready, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule